// File: doc/BRIEF.md
# Sequential 32-bit Multiply/Divide Unit

This unit computes all eight integer multiply, divide and remainder operations of the standard RISC-V M extension on two 32-bit operands. The operation is chosen by a 3-bit function code. A single-cycle `start` pulse latches the operands and the code, and the unit then works for a fixed number of cycles. `busy` is high during that time, and `done` rises when the answer appears on `result`.

Internally the operands are reduced to magnitudes according to the signedness of each operation. One 64-bit register does the work for both kinds of operation. For a multiply it runs an add-and-shift loop. For a divide it runs a radix-2 restoring loop. The signs are applied once the loop ends. The exact architectural results for division by zero and for signed overflow come out without any trap.

Top module: `mdu_seq`

## Requirements
- R1: Code 000 computes the low 32 bits of a*b, with both operands signed. Code 001 computes the high 32 bits of the signed*signed product. Code 010 computes the high 32 bits with a signed and b unsigned. Code 011 computes the high 32 bits with both operands unsigned.
- R2: Code 100 is signed divide and code 101 is unsigned divide. Signed quotients truncate toward zero.
- R3: Code 110 is signed remainder and code 111 is unsigned remainder. A signed remainder takes the sign of the dividend.
- R4: A divide by zero (code 100 or 101) returns 0xFFFFFFFF.
- R5: A remainder by zero (code 110 or 111) returns the dividend unchanged.
- R6: Signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000. The matching signed remainder returns 0.
- R7: After reset, `busy` and `done` are low.
- R8: When `start` is sampled high while the unit is not busy, `busy` is high from the next cycle. `done` rises exactly 32 clock edges after the edge that sampled `start`, and at the same time `busy` falls. `busy` and `done` are never high together.
- R9: While `done` is high and `start` is low, `done` stays high and `result` holds its value.
- R10: `start`, `op`, `a` and `b` are ignored while `busy` is high. The operation in flight completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted when not busy |
| op | input | 3 | Function code (see R1 to R3) |
| a | input | 32 | First operand / dividend |
| b | input | 32 | Second operand / divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid; held until the next accepted start |
| result | output | 32 | Operation result |

## Verification
Random operands almost never produce a zero divisor, or the most negative dividend paired with a divisor of minus one. Yet these are the cases where the magnitude loop alone would give the wrong sign or value. The stimulus therefore crosses every function code with every pair drawn from 0, 1, -1, 0x80000000 and one random value, and then runs constrained random operands. In some runs, a competing `start` carrying different operands is driven mid-operation. This shows that the in-flight result still matches the original operands.

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CW = $clog2(W);

  logic [2*W-1:0] acc;
  logic [W-1:0]   dvs, a_q;
  logic [2:0]     op_q;
  logic           nq, nr, dz, busy_q, done_q;
  logic [CW-1:0]  cnt;

  wire accept = start && !busy_q;

  wire a_sgn = op[2] ? ~op[0] : (op != 3'b011);
  wire b_sgn = op[2] ? ~op[0] : ~op[1];
  wire na    = a_sgn & a[W-1];
  wire nb    = b_sgn & b[W-1];
  wire [W-1:0] amag = na ? -a : a;
  wire [W-1:0] bmag = nb ? -b : b;

  wire [W:0]     msum   = {1'b0, acc[2*W-1:W]} + {1'b0, (acc[0] ? dvs : {W{1'b0}})};
  wire [2*W-1:0] mul_nx = {msum, acc[W-1:1]};
  wire [W:0]     dtry   = acc[2*W-1:W-1] - {1'b0, dvs};
  wire [2*W-1:0] div_nx = dtry[W] ? {acc[2*W-2:0], 1'b0}
                                  : {dtry[W-1:0], acc[W-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      dvs    <= '0;
      a_q    <= '0;
      op_q   <= '0;
      nq     <= 1'b0;
      nr     <= 1'b0;
      dz     <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      acc    <= {{W{1'b0}}, amag};
      dvs    <= bmag;
      a_q    <= a;
      op_q   <= op;
      nq     <= na ^ nb;
      nr     <= na;
      dz     <= (b == '0);
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt    <= '0;
    end else if (busy_q) begin
      acc <= op_q[2] ? div_nx : mul_nx;
      cnt <= cnt + 1'b1;
      if (cnt == CW'(W-1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  wire [2*W-1:0] prod = nq ? -acc : acc;
  wire [W-1:0]   quo  = nq ? -acc[W-1:0] : acc[W-1:0];
  wire [W-1:0]   rem  = nr ? -acc[2*W-1:W] : acc[2*W-1:W];
  wire [W-1:0]   mres = (op_q[1:0] == 2'b00) ? prod[W-1:0] : prod[2*W-1:W];
  wire [W-1:0]   dres = op_q[1] ? (dz ? a_q : rem) : (dz ? {W{1'b1}} : quo);

  assign result = op_q[2] ? dres : mres;
  assign busy   = busy_q;
  assign done   = done_q;

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_q, done_q}));

  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy_q |=> busy_q && !done_q);

  a_r8_run: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && cnt != CW'(W-1) |=> busy_q);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start |=> done_q && $stable(result));

  a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(op_q) && $stable(dvs) && $stable(a_q));
endmodule

// File: tb/mdu_seq_bench.sv
module mdu_seq_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;
  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  mdu_seq u_mdu_seq (.clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
                     .busy(busy), .done(done), .result(result));

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y);
    longint sx, sy, p;
    sx = (f != 3'b011) ? longint'($signed(x)) : longint'({32'd0, x});
    sy = (f[1] == 1'b0) ? longint'($signed(y)) : longint'({32'd0, y});
    p  = sx * sy;
    case (f)
      3'b000: return p[31:0];
      3'b001, 3'b010, 3'b011: return p[63:32];
      3'b100: begin
        if (y == 0) return 32'hFFFF_FFFF;
        if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return 32'h8000_0000;
        return $signed(x) / $signed(y);
      end
      3'b101: return (y == 0) ? 32'hFFFF_FFFF : x / y;
      3'b110: begin
        if (y == 0) return x;
        if (y == 32'hFFFF_FFFF) return 32'd0;
        return $signed(x) % $signed(y);
      end
      default: return (y == 0) ? x : x % y;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] f, input logic [31:0] y, input logic [31:0] x);
    if (f[2] && y == 0) return f[1] ? "R5" : "R4";
    if (f == 3'b100 && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R6";
    if (f == 3'b110 && x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R6";
    if (!f[2]) return "R1";
    return f[1] ? "R3" : "R2";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] f, input logic [31:0] x, input logic [31:0] y, input bit intrude);
    int cyc;
    logic [31:0] exp, held;
    exp = model(f, x, y);
    @(negedge clk);
    op = f; a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 busy after start", {31'd0, busy}, 32'd1);
    cyc = 0;
    while (!done && cyc < 100) begin
      if (intrude && cyc == 5) begin
        op = ~f; a = ~x; b = y + 32'd3; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check("R8 latency", cyc, 32'd32);
    check(intrude ? "R10 intruding start" : tag(f, y, x), result, exp);
    held = result;
    op = ~f; a = $urandom; b = $urandom;
    repeat (2) @(negedge clk);
    check("R9 done held", {31'd0, done}, 32'd1);
    check("R9 result held", result, held);
  endtask

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'd0; corner[1] = 32'd1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h1234_5679;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R7 busy reset", {31'd0, busy}, 32'd0);
    check("R7 done reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run(3'(f), corner[i], corner[j], 1'b0);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] x, y;
      x = $urandom;
      y = $urandom;
      if (k % 4 == 1) y = y >> ($urandom % 32);
      if (k % 4 == 2) y = -($urandom % 8);
      run(3'($urandom % 8), x, y, (k % 10 == 3));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule